// File: doc/BRIEF.md
# Up/Down Timer with Selectable Direction Source

This block is a general-purpose 16-bit timer/counter. It counts rising edges of an external clock pin against an internal period register. The external clock pin is brought into the internal clock domain before its edges are detected, so no asynchronous counting path exists. Each count step goes up or down. The direction comes either from an external direction pin or from a software direction bit, and a source-select control bit picks between the two at run time.

When counting up past the period value, the counter returns to zero. When counting down past zero, it reloads the period value. A one-cycle match pulse is raised whenever a count step lands on the period value. Software reaches the count, the period and a four-bit control word through a write-strobe interface that shares one data bus. Counting can be held in three ways: a run bit in the control word, a stop-in-idle bit combined with an idle request input, and a module-enable input that models the clock stop of sleep mode. None of these holds, and no control write, alters the stored count.

Top module: `updn_timer`

## Requirements
- R1: After reset, count is 0, period is 16'hFFFF, match_irq is 0, and every control bit is 0.
- R2: A rising edge on ext_clk moves the count by one step, and the new count appears after the third rising clk edge following the pin's rise. A falling edge of ext_clk never moves the count.
- R3: Control bit 0 is the direction source. When it is 1, the direction follows ext_dir (after synchronisation). When it is 0, the direction follows control bit 1.
- R4: A direction level of 1 increments the count and a level of 0 decrements it. The level in use is visible on count_up.
- R5: When counting up from a count equal to the period, the next count is 0.
- R6: When counting down from a count of 0, the next count is the period value.
- R7: match_irq is high for exactly one cycle, in the same cycle that a count step makes the count equal to the period.
- R8: When control bit 2 (stop-in-idle) is 1 and idle_req is high, counting halts. When bit 2 is 0, counting continues while idle_req is high.
- R9: While mod_en is 0, the count does not advance.
- R10: A count write (wr_cnt) loads wr_data and takes priority over a count step in the same cycle.
- R11: Control bit 3 is the run bit, and the count advances only while it is 1. Writing the control word (wr_ctl, data bits 3:0) never changes the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | External count clock pin, asynchronous |
| ext_dir | input | 1 | External direction pin, 1 = up |
| idle_req | input | 1 | Idle mode request |
| mod_en | input | 1 | Module clock enable; 0 models sleep |
| wr_cnt | input | 1 | Write strobe for the count |
| wr_per | input | 1 | Write strobe for the period |
| wr_ctl | input | 1 | Write strobe for the control word (data bits 3:0) |
| wr_data | input | 16 | Write data shared by all strobes |
| count | output | 16 | Current count |
| period | output | 16 | Current period |
| match_irq | output | 1 | Single-cycle period-match pulse |
| count_up | output | 1 | Direction currently in use, 1 = up |

## Verification
Several rules are checked by assertions on every cycle. These are the wrap to zero and the reload from zero, the priority of a count write, the frozen count while the module is disabled, and the match pulse's width and its agreement with the period. Only the bench's scenarios can show the rest. This covers the three-edge latency from the pin to the count, and the fact that falling edges are ignored. It also covers the direction that results from each source-select and pin combination, the stop-in-idle gating, and whether a run of steps ends on the right count with the right number of pulses.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    localparam int CTL_W = 4;

    // Control word, bit 3 down to bit 0
    typedef struct packed {
        logic run;        // bit 3
        logic stop_idle;  // bit 2
        logic sw_up;      // bit 1
        logic dir_src;    // bit 0: 1 = pin
    } ctl_t;

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] sync_prev
);
    logic [W-1:0] stage_q [STAGES+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i <= STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out  = stage_q[STAGES-1];
    assign sync_prev = stage_q[STAGES];
endmodule

// File: rtl/updn_dir_sel.sv
module updn_dir_sel
    import updn_timer_pkg::*;
(
    input  ctl_t ctl,
    input  logic pin_dir,
    output logic up
);
    always_comb begin
        up = ctl.dir_src ? pin_dir : ctl.sw_up;
    end
endmodule

// File: rtl/updn_core.sv
module updn_core
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             up,
    input  logic             idle_req,
    input  logic             mod_en,
    input  logic             wr_cnt,
    input  logic             wr_per,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per,
    output ctl_t             ctl,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        ctl_t             ctl;
        logic             irq;
    } state_t;

    state_t st_q, st_d;
    logic             advance;
    logic [CNT_W-1:0] step_val;

    always_comb begin
        advance = tick && mod_en && st_q.ctl.run &&
                  !(st_q.ctl.stop_idle && idle_req);
        if (up) step_val = (st_q.cnt == st_q.per) ? ZERO : st_q.cnt + ONE;
        else    step_val = (st_q.cnt == ZERO) ? st_q.per : st_q.cnt - ONE;

        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_cnt) begin
            st_d.cnt = wr_data;
        end else if (advance) begin
            st_d.cnt = step_val;
            st_d.irq = (step_val == st_q.per) && !wr_per;
        end
        if (wr_per) st_d.per = wr_data;
        if (wr_ctl) st_d.ctl = ctl_t'(wr_data[CTL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.per <= '1;
            st_q.ctl <= '0;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign per = st_q.per;
    assign ctl = st_q.ctl;
    assign irq = st_q.irq;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt == $past(wr_data)); // R10
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && !wr_cnt) |=> $stable(cnt)); // R9
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && up && !wr_cnt && cnt == per) |=> cnt == ZERO); // R5
    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !up && !wr_cnt && cnt == ZERO && !wr_per) |=> cnt == per); // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_IRQ_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt == per); // R7
    AST_CTL_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wr_cnt && !advance) |=> $stable(cnt)); // R11
endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic             ext_dir,
    input  logic             idle_req,
    input  logic             mod_en,
    input  logic             wr_cnt,
    input  logic             wr_per,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] period,
    output logic             match_irq,
    output logic             count_up
);
    logic clk_s, clk_prev, dir_s, dir_prev_unused;
    logic tick, up;
    ctl_t ctl;

    updn_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_clk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk),
        .sync_out(clk_s), .sync_prev(clk_prev)
    );

    updn_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_dir_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_dir),
        .sync_out(dir_s), .sync_prev(dir_prev_unused)
    );

    assign tick = clk_s && !clk_prev;

    updn_dir_sel u_dir (
        .ctl(ctl), .pin_dir(dir_s), .up(up)
    );

    updn_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .up(up),
        .idle_req(idle_req), .mod_en(mod_en),
        .wr_cnt(wr_cnt), .wr_per(wr_per), .wr_ctl(wr_ctl), .wr_data(wr_data),
        .cnt(count), .per(period), .ctl(ctl), .irq(match_irq)
    );

    assign count_up = up;

    AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: tb/sim_updn_timer.sv
`timescale 1ns/1ps
module sim_updn_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0, ext_dir = 1'b0, idle_req = 1'b0, mod_en = 1'b1;
    logic        wr_cnt = 1'b0, wr_per = 1'b0, wr_ctl = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count, period;
    logic        match_irq, count_up;

    int checks = 0, failures = 0, irq_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    updn_timer u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_dir(ext_dir),
        .idle_req(idle_req), .mod_en(mod_en), .wr_cnt(wr_cnt), .wr_per(wr_per),
        .wr_ctl(wr_ctl), .wr_data(wr_data), .count(count), .period(period),
        .match_irq(match_irq), .count_up(count_up)
    );

    always @(negedge clk) if (match_irq) irq_seen++;

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] start;
        logic [3:0]  ctl;   // {run, stop_idle, sw_up, dir_src}
        logic        dir;
        logic        idle;
        logic        en;
        logic [7:0]  n;
        logic [15:0] exp;
        logic [7:0]  irqs;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'd10,  16'd0,  4'hA, 1'b0, 1'b0, 1'b1, 8'd3, 16'd3,  8'd0, 8'd4},  // R4 up
        '{16'd5,   16'd4,  4'hA, 1'b0, 1'b0, 1'b1, 8'd3, 16'd1,  8'd1, 8'd5},  // R5 wrap
        '{16'd5,   16'd2,  4'h8, 1'b0, 1'b0, 1'b1, 8'd4, 16'd4,  8'd1, 8'd6},  // R6 reload
        '{16'd100, 16'd10, 4'h9, 1'b1, 1'b0, 1'b1, 8'd2, 16'd12, 8'd0, 8'd3},  // R3 pin up
        '{16'd100, 16'd10, 4'hB, 1'b0, 1'b0, 1'b1, 8'd2, 16'd8,  8'd0, 8'd3},  // R3 pin down
        '{16'd100, 16'd7,  4'hE, 1'b0, 1'b1, 1'b1, 8'd3, 16'd7,  8'd0, 8'd8},  // R8 halted
        '{16'd100, 16'd7,  4'hA, 1'b0, 1'b1, 1'b1, 8'd3, 16'd10, 8'd0, 8'd8},  // R8 idle runs
        '{16'd100, 16'd7,  4'hE, 1'b0, 1'b0, 1'b1, 8'd3, 16'd10, 8'd0, 8'd8},  // R8 not idle
        '{16'd100, 16'd7,  4'hA, 1'b0, 1'b0, 1'b0, 8'd3, 16'd7,  8'd0, 8'd9},  // R9 sleep
        '{16'd100, 16'd7,  4'h2, 1'b0, 1'b0, 1'b1, 8'd3, 16'd7,  8'd0, 8'd11}, // R11 run off
        '{16'd3,   16'd0,  4'hA, 1'b0, 1'b0, 1'b1, 8'd3, 16'd3,  8'd1, 8'd7}   // R7 match
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int kind, input logic [15:0] d);
        @(negedge clk);
        wr_data = d;
        wr_cnt = (kind == 0);
        wr_per = (kind == 1);
        wr_ctl = (kind == 2);
        @(negedge clk);
        wr_cnt = 1'b0; wr_per = 1'b0; wr_ctl = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk) ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        ext_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 period", period, 16'hFFFF);
        chk("R1 irq", match_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 run off, count_up from sw bit", count_up, 0);

        foreach (VECS[i]) begin
            ext_dir  = VECS[i].dir;
            idle_req = VECS[i].idle;
            mod_en   = VECS[i].en;
            wr(1, VECS[i].per);
            wr(0, VECS[i].start);
            wr(2, {12'h0, VECS[i].ctl});
            repeat (3) @(negedge clk);
            irq_seen = 0;
            for (int p = 0; p < int'(VECS[i].n); p++) pulse();
            repeat (4) @(negedge clk);
            chk($sformatf("R%0d vec%0d count", VECS[i].req, i), count, VECS[i].exp);
            chk($sformatf("R%0d vec%0d irq", VECS[i].req, i), irq_seen, VECS[i].irqs);
        end
        idle_req = 1'b0; mod_en = 1'b1;

        // R3 R4 direction visible on count_up
        wr(2, 16'h9); ext_dir = 1'b1; repeat (3) @(negedge clk);
        chk("R3 pin up", count_up, 1);
        ext_dir = 1'b0; repeat (3) @(negedge clk);
        chk("R3 pin down", count_up, 0);
        wr(2, 16'hA);
        chk("R4 sw up", count_up, 1);

        // R2 timing: step lands on the third clk edge after the pin rises
        wr(1, 16'd100); wr(0, 16'd20);
        repeat (3) @(negedge clk);
        ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 not yet", count, 20);
        @(negedge clk);
        chk("R2 stepped", count, 21);
        ext_clk = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 falling ignored", count, 21);

        // R10 write beats a step in the same cycle
        ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        wr_data = 16'h1234; wr_cnt = 1'b1;
        @(negedge clk);
        wr_cnt = 1'b0;
        chk("R10 write wins", count, 16'h1234);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 no later step", count, 16'h1234);

        // R11 control writes keep the count
        wr(2, 16'h0); @(negedge clk);
        chk("R11 ctl write off", count, 16'h1234);
        wr(2, 16'h8); @(negedge clk);
        chk("R11 ctl write on", count, 16'h1234);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule